// File: doc/BRIEF.md
# ECC Poison Injection Controller

The controller sits on the write path in front of a memory controller's ECC encoder. It plants forced errors (poison) for diagnostics in the field. Software asks for a poison setting: off, one corrupted bit or two corrupted bits, together with a target address.

The request is not applied at once. The controller first holds a stall on every requester port. It then waits until no port has outstanding address or data beats, no refresh is running and no access is being presented. Only then does it commit the new setting, and it releases the stall on the next cycle. No reset and no retraining of the memory interface is needed.

After the setting is committed, the controller corrupts exactly one access to the target address. It then waits for the ECC checker's verdict on that access. It reports the verdict with a one-cycle done pulse and captured correctable and uncorrectable flags, and it raises an interrupt pulse when the error is uncorrectable. The committed setting stays visible and in force until software writes a new one or uses the restore input to return to no poison.

Top module: `ecc_poison_ctrl`

## Requirements
- R1: A request (`cfg_valid` or `cfg_restore`) seen while not busy makes `busy` high from the next cycle. `active_mode` and `active_addr` keep their old values until the commit.
- R2: The pending setting is committed on the first clock edge at which `port_pending` is all zero, `refresh_active` is low and `acc_valid` is low. From the cycle after that edge, `busy` is low and the new setting is visible.
- R3: `stall` is high on every port in every cycle that `busy` is high, and low on every port otherwise.
- R4: After a commit, only the first access to `active_addr` has its data altered. Accesses to other addresses, and later accesses to the target, pass through with `mem_data` equal to `acc_data`.
- R5: Mode encoding: 2'b01 flips data bit 0, 2'b10 flips data bits 0 and 1, and 2'b00 flips nothing. 2'b11 is reserved: it commits as 2'b00 and flips nothing.
- R6: The committed setting persists across accesses until it is rewritten. `cfg_restore` commits mode 2'b00 and keeps the current address.
- R7: The first `rsp_valid` after the corrupted access makes `done` pulse for one cycle on the next cycle, with `stat_ce` and `stat_ue` copying `rsp_ce` and `rsp_ue`. `irq_ue` pulses in the same cycle only when `rsp_ue` was set.
- R8: A request arriving while `busy` is high is dropped and not queued, and it sets `cfg_err`. `cfg_err` stays set until reset.
- R9: After synchronous reset: `busy`, `stall`, `cfg_err`, `done` and `irq_ue` are low, and `active_mode` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Poison setting request |
| cfg_mode | input | 2 | Requested mode (00 off, 01 one bit, 10 two bits, 11 reserved) |
| cfg_addr | input | AW | Requested target address |
| cfg_restore | input | 1 | Request return to no poison |
| busy | output | 1 | Waiting for quiescence to commit |
| cfg_err | output | 1 | Sticky: a request was dropped while busy |
| active_mode | output | 2 | Committed mode |
| active_addr | output | AW | Committed target address |
| port_pending | input | NP | Per-port outstanding beats flag |
| refresh_active | input | 1 | Refresh in progress |
| stall | output | NP | Per-port hold |
| acc_valid | input | 1 | Access presented |
| acc_addr | input | AW | Access address |
| acc_data | input | DW | Access data from requester |
| mem_data | output | DW | Data toward ECC encoder, possibly corrupted |
| rsp_valid | input | 1 | ECC checker verdict valid |
| rsp_ce | input | 1 | Checker corrected an error |
| rsp_ue | input | 1 | Checker found an uncorrectable error |
| done | output | 1 | One-cycle pulse: verdict for the target captured |
| stat_ce | output | 1 | Captured correctable flag |
| stat_ue | output | 1 | Captured uncorrectable flag |
| irq_ue | output | 1 | Uncorrectable-error interrupt pulse |

## Verification
The commit and a rejection can fall on the same clock edge. This happens when a second request arrives in the very cycle the ports go idle. The bench provokes it by dropping `port_pending` and raising `cfg_valid` with a different mode at the same falling edge. It then judges that the first setting was committed, `cfg_err` became set, and no second commit follows in the later idle cycles. A checker stub in the bench counts the bits flipped on each access and returns the verdict, and a scoreboard matches every done pulse against the verdict queued when the target access was driven.

// File: rtl/ecc_poison_pkg.sv
package ecc_poison_pkg;

    typedef enum logic [1:0] {
        PM_OFF    = 2'b00,
        PM_ONE    = 2'b01,
        PM_TWO    = 2'b10,
        PM_RSVD   = 2'b11
    } poison_mode_e;

    typedef enum logic [0:0] {
        CS_IDLE = 1'b0,
        CS_WAIT = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic ce;
        logic ue;
    } chk_verdict_t;

    localparam int FLIP_W = 2;

    // Reserved encoding collapses to off.
    function automatic poison_mode_e norm_mode(input logic [1:0] raw);
        poison_mode_e m;
        m = poison_mode_e'(raw);
        return (m == PM_RSVD) ? PM_OFF : m;
    endfunction

    // Low-order corruption pattern for each mode.
    function automatic logic [FLIP_W-1:0] flip_pattern(input poison_mode_e m);
        case (m)
            PM_ONE:  return 2'b01;
            PM_TWO:  return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/epi_quiesce.sv
module epi_quiesce #(
    parameter int NP = 3
) (
    input  logic          hold,
    input  logic [NP-1:0] port_pending,
    input  logic          refresh_active,
    input  logic          acc_valid,
    output logic          quiet,
    output logic [NP-1:0] stall
);
    assign quiet = (port_pending == '0) && !refresh_active && !acc_valid;

    for (genvar p = 0; p < NP; p++) begin : g_port
        assign stall[p] = hold;
    end

endmodule

// File: rtl/epi_inject.sv
module epi_inject
    import ecc_poison_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          armed,
    input  poison_mode_e  mode,
    input  logic [AW-1:0] target,
    input  logic          acc_valid,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_data,
    output logic [DW-1:0] mem_data,
    output logic          hit
);
    localparam int PAD_W = DW - FLIP_W;

    logic [DW-1:0] mask;

    assign hit      = armed && acc_valid && (acc_addr == target);
    assign mask     = hit ? {{PAD_W{1'b0}}, flip_pattern(mode)} : '0;
    assign mem_data = acc_data ^ mask;

    AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (rst)
        !armed |-> (mem_data == acc_data)) else $error("unarmed corruption"); // R4

endmodule

// File: rtl/epi_ctrl.sv
module epi_ctrl
    import ecc_poison_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_valid,
    input  logic [1:0]    cfg_mode,
    input  logic [AW-1:0] cfg_addr,
    input  logic          cfg_restore,
    input  logic          quiet,
    input  logic          hit,
    input  logic          rsp_valid,
    input  logic          rsp_ce,
    input  logic          rsp_ue,
    output logic          busy,
    output logic          cfg_err,
    output poison_mode_e  act_mode,
    output logic [AW-1:0] act_addr,
    output logic          armed,
    output logic          done,
    output chk_verdict_t  verdict,
    output logic          irq_ue
);
    ctl_state_e    state;
    poison_mode_e  pend_mode;
    logic [AW-1:0] pend_addr;
    logic          wait_rsp;
    logic          req;

    assign req  = cfg_valid || cfg_restore;
    assign busy = (state == CS_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= CS_IDLE;
            pend_mode <= PM_OFF;
            pend_addr <= '0;
            act_mode  <= PM_OFF;
            act_addr  <= '0;
            armed     <= 1'b0;
            wait_rsp  <= 1'b0;
            cfg_err   <= 1'b0;
            done      <= 1'b0;
            verdict   <= '0;
            irq_ue    <= 1'b0;
        end else begin
            done   <= 1'b0;
            irq_ue <= 1'b0;

            if (wait_rsp && rsp_valid) begin
                done     <= 1'b1;
                verdict  <= '{ce: rsp_ce, ue: rsp_ue};
                irq_ue   <= rsp_ue;
                wait_rsp <= 1'b0;
            end

            if (hit) begin
                armed    <= 1'b0;
                wait_rsp <= 1'b1;
            end

            case (state)
                CS_IDLE: begin
                    if (req) begin
                        state     <= CS_WAIT;
                        pend_mode <= cfg_restore ? PM_OFF : norm_mode(cfg_mode);
                        pend_addr <= cfg_restore ? act_addr : cfg_addr;
                    end
                end
                CS_WAIT: begin
                    if (req) begin
                        cfg_err <= 1'b1;
                    end
                    if (quiet) begin
                        state    <= CS_IDLE;
                        act_mode <= pend_mode;
                        act_addr <= pend_addr;
                        armed    <= (pend_mode != PM_OFF);
                        wait_rsp <= 1'b0;
                    end
                end
                default: state <= CS_IDLE;
            endcase
        end
    end

    AST_COMMIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!$stable(act_mode) || !$stable(act_addr)) |-> $past(quiet)) else $error("commit not quiet"); // R2

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        hit |=> !armed) else $error("second injection armed"); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than one cycle"); // R7

    AST_IRQ_UE: assert property (@(posedge clk) disable iff (rst)
        irq_ue |-> (done && verdict.ue)) else $error("irq without ue verdict"); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err) else $error("error flag cleared"); // R8

endmodule

// File: rtl/ecc_poison_ctrl.sv
module ecc_poison_ctrl
    import ecc_poison_pkg::*;
#(
    parameter int NP = 3,
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_valid,
    input  logic [1:0]    cfg_mode,
    input  logic [AW-1:0] cfg_addr,
    input  logic          cfg_restore,
    output logic          busy,
    output logic          cfg_err,
    output logic [1:0]    active_mode,
    output logic [AW-1:0] active_addr,
    input  logic [NP-1:0] port_pending,
    input  logic          refresh_active,
    output logic [NP-1:0] stall,
    input  logic          acc_valid,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_data,
    output logic [DW-1:0] mem_data,
    input  logic          rsp_valid,
    input  logic          rsp_ce,
    input  logic          rsp_ue,
    output logic          done,
    output logic          stat_ce,
    output logic          stat_ue,
    output logic          irq_ue
);
    logic         quiet;
    logic         hit;
    logic         armed;
    poison_mode_e act_mode;
    chk_verdict_t verdict;

    epi_quiesce #(.NP(NP)) u_quiesce (
        .hold           (busy),
        .port_pending   (port_pending),
        .refresh_active (refresh_active),
        .acc_valid      (acc_valid),
        .quiet          (quiet),
        .stall          (stall)
    );

    epi_ctrl #(.AW(AW)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cfg_valid   (cfg_valid),
        .cfg_mode    (cfg_mode),
        .cfg_addr    (cfg_addr),
        .cfg_restore (cfg_restore),
        .quiet       (quiet),
        .hit         (hit),
        .rsp_valid   (rsp_valid),
        .rsp_ce      (rsp_ce),
        .rsp_ue      (rsp_ue),
        .busy        (busy),
        .cfg_err     (cfg_err),
        .act_mode    (act_mode),
        .act_addr    (active_addr),
        .armed       (armed),
        .done        (done),
        .verdict     (verdict),
        .irq_ue      (irq_ue)
    );

    epi_inject #(.AW(AW), .DW(DW)) u_inject (
        .clk       (clk),
        .rst       (rst),
        .armed     (armed),
        .mode      (act_mode),
        .target    (active_addr),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_data  (acc_data),
        .mem_data  (mem_data),
        .hit       (hit)
    );

    assign active_mode = act_mode;
    assign stat_ce     = verdict.ce;
    assign stat_ue     = verdict.ue;

endmodule

// File: tb/test_ecc_poison_ctrl.sv
module test_ecc_poison_ctrl;
    localparam int NP = 3;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_valid = 1'b0;
    logic [1:0]    cfg_mode = 2'b00;
    logic [AW-1:0] cfg_addr = '0;
    logic          cfg_restore = 1'b0;
    logic          busy, cfg_err;
    logic [1:0]    active_mode;
    logic [AW-1:0] active_addr;
    logic [NP-1:0] port_pending = '0;
    logic          refresh_active = 1'b0;
    logic [NP-1:0] stall;
    logic          acc_valid = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [DW-1:0] acc_data = '0;
    logic [DW-1:0] mem_data;
    logic          rsp_valid = 1'b0, rsp_ce = 1'b0, rsp_ue = 1'b0;
    logic          done, stat_ce, stat_ue, irq_ue;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct { logic ce; logic ue; } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;   // 250 MHz

    ecc_poison_ctrl #(.NP(NP), .AW(AW), .DW(DW)) i_ecc_poison_ctrl (.*);

    // ECC checker stub: verdict one cycle after each access
    always @(posedge clk) begin
        rsp_valid <= acc_valid;
        rsp_ce    <= acc_valid && ($countones(mem_data ^ acc_data) == 1);
        rsp_ue    <= acc_valid && ($countones(mem_data ^ acc_data) == 2);
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pops scoreboard on each done pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            n_run++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL R7: actual unexpected done expected none");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if ({stat_ce, stat_ue, irq_ue} !== {e.ce, e.ue, e.ue}) begin
                    n_fail++;
                    $display("FAIL R7: actual %b expected %b", {stat_ce, stat_ue, irq_ue}, {e.ce, e.ue, e.ue});
                end
            end
        end
    end

    task automatic request(input logic [1:0] m, input logic [AW-1:0] a, input logic rest);
        @(negedge clk);
        cfg_valid = !rest; cfg_restore = rest; cfg_mode = m; cfg_addr = a;
        @(negedge clk);
        cfg_valid = 1'b0; cfg_restore = 1'b0;
    endtask

    task automatic access(input string req, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [DW-1:0] exp_d, input logic push, input logic ce, input logic ue);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_data = d;
        if (push) sb_q.push_back('{ce: ce, ue: ue});
        #1 chk(req, mem_data, exp_d);
        @(negedge clk);
        acc_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 reset", {busy, stall, cfg_err, done, irq_ue, active_mode}, '0);

        // R1/R2/R3: single-bit request held off by pending beats, then refresh
        port_pending = 3'b010;
        request(2'b01, 16'h0040, 1'b0);
        chk("R1 busy", busy, 1'b1);
        chk("R3 stall all", stall, 3'b111);
        chk("R1 old setting kept", active_mode, 2'b00);
        @(negedge clk);
        port_pending = '0; refresh_active = 1'b1;
        @(negedge clk);
        chk("R2 held by refresh", busy, 1'b1);
        refresh_active = 1'b0;
        @(negedge clk);
        chk("R2 committed", {busy, active_mode, active_addr}, {1'b0, 2'b01, 16'h0040});
        chk("R3 stall released", stall, 3'b000);

        // R4/R5/R7: one-bit injection
        access("R4 other addr passes", 16'h0010, 32'hA5A5_0F0F, 32'hA5A5_0F0F, 1'b0, 1'b0, 1'b0);
        access("R5 one bit flipped", 16'h0040, 32'h1234_5678, 32'h1234_5679, 1'b1, 1'b1, 1'b0);
        access("R4 second target access clean", 16'h0040, 32'h1234_5678, 32'h1234_5678, 1'b0, 1'b0, 1'b0);
        chk("R6 setting persists", active_mode, 2'b01);

        // R5/R7: two-bit injection raises interrupt
        request(2'b10, 16'h0080, 1'b0);
        @(negedge clk);
        chk("R2 double committed", {busy, active_mode}, {1'b0, 2'b10});
        access("R5 two bits flipped", 16'h0080, 32'hFFFF_0000, 32'hFFFF_0003, 1'b1, 1'b0, 1'b1);

        // R5: reserved treated as off
        request(2'b11, 16'h0090, 1'b0);
        @(negedge clk);
        chk("R5 reserved commits off", active_mode, 2'b00);
        access("R5 reserved no flip", 16'h0090, 32'h0000_00FF, 32'h0000_00FF, 1'b0, 1'b0, 1'b0);

        // R8: second request on the commit edge is dropped
        port_pending = 3'b001;
        request(2'b01, 16'h0020, 1'b0);
        @(negedge clk);
        port_pending = '0; cfg_valid = 1'b1; cfg_mode = 2'b10; cfg_addr = 16'h0030;
        @(negedge clk);
        cfg_valid = 1'b0;
        chk("R8 err set", cfg_err, 1'b1);
        chk("R8 first setting committed", {active_mode, active_addr}, {2'b01, 16'h0020});
        repeat (3) @(negedge clk);
        chk("R8 not queued", {busy, active_mode, active_addr}, {1'b0, 2'b01, 16'h0020});

        // R6: restore returns to off, address kept
        request(2'b00, 16'h0000, 1'b1);
        @(negedge clk);
        chk("R6 restore", {active_mode, active_addr, cfg_err}, {2'b00, 16'h0020, 1'b1});
        access("R6 restored no flip", 16'h0020, 32'hCAFE_0001, 32'hCAFE_0001, 1'b0, 1'b0, 1'b0);

        chk("R7 all verdicts seen", sb_q.size(), 0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule